// File: doc/BRIEF.md
# March Algorithm Memory Self-Test Sequencer

This block runs a march-style self-test on a bit-wide synchronous RAM whose cells sit in a grid of `ROWS` rows by `COLS` columns. A pulse on `start` latches a two-bit test selector and begins the test. The sequencer then issues exactly one memory operation per clock (a write with its data bit, or a read). Each read is compared with its expected bit on the following clock. When the test ends, `done` rises and holds. The `fail` flag reports whether any read mismatched, and the first mismatch is kept: its address, the index of the march element it occurred in, and the bit that was expected.

A march element pairs one address direction with a fixed list of one or two operations. All operations of an element are applied at one address before the address moves. Three tests are built in: a three-element test that catches stuck-at and address faults; a four-pass solid zero-one scan; and the same scan with a checkerboard background. The checkerboard data comes from the physical row and column of each cell, not from the low address bits. A parameter decides whether the sequencer stops at the first mismatch or runs to the end.

The control is a four-state machine:
- IDLE goes to RUN on an accepted start.
- RUN goes to DRAIN after the last operation has been issued.
- RUN goes directly to DONE on a mismatch when halting is enabled.
- DRAIN goes to DONE one cycle later, once the final read has been compared.
- DONE goes to RUN on a new start.

Top module: `mbist_march_ctrl`

## Requirements
- R1: With `mode` = 2'b00 the test has three elements. Element 0 writes 0 to every cell in ascending address order. Element 1, ascending, reads an expected 0 and then writes 1 at each address. Element 2, descending from DEPTH-1 to 0, reads an expected 1 and then writes 0 at each address. This is 5·DEPTH operations in total.
- R2: With `mode` = 2'b01 the test has four ascending single-operation elements, numbered 0 to 3: write 0, read 0, write 1, read 1. This is 4·DEPTH operations.
- R3: With `mode` = 2'b10 or 2'b11 the sequence of R2 is used, but every data bit and expected bit is XORed with the cell parity. The parity is bit 0 of (address / COLS) XOR bit 0 of (address % COLS).
- R4: One operation is issued per clock while in RUN. `mem_we` and `mem_re` are never both high. No access occurs outside RUN. Every address lies in 0..DEPTH-1. The first operation appears in the cycle after the clock edge that accepts `start`.
- R5: `mem_rdata` is sampled in the cycle after the read is issued. A mismatch shows on `fail` and on the capture outputs two clock edges after the read's issue cycle begins.
- R6: The first mismatch after a start loads `fail_addr`, `fail_elem` (element index, counted from 0 in program order) and `fail_exp`. Later mismatches do not change these outputs.
- R7: `fail` and the capture outputs stay constant until the next accepted start, and that start clears them to 0.
- R8: `busy` is high from the first operation until the final compare (RUN and DRAIN). `done` rises in the cycle after DRAIN, never together with `busy`, and holds until the next accepted start.
- R9: A `start` pulse while `busy` is high is ignored: the operation stream continues unchanged.
- R10: With `HALT_ON_FAIL` = 1, the sequencer enters DONE on the same edge that sets `fail`, and issues no further accesses. With 0, it runs to completion.
- R11: After reset: `busy`, `done`, `fail`, `mem_we` and `mem_re` are 0, and `fail_addr` is 0.
- R12: A cell stuck at 0 or at 1, anywhere in the array, is reported as a failure by every test, because each test reads both values from every cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a test (accepted in IDLE or DONE) |
| mode | input | 2 | Test select: 00 three-element, 01 zero-one, 1x checkerboard |
| mem_addr | output | ADDR_W | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable (data returned next cycle) |
| mem_wdata | output | 1 | Memory write data |
| mem_rdata | input | 1 | Memory read data |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished |
| fail | output | 1 | At least one read mismatched |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_elem | output | 2 | Element index of the first mismatch |
| fail_exp | output | 1 | Expected bit of the first mismatch |

## Verification
The bench uses a 4-row by 8-column array of 32 cells. With this grid the row parity lives in address bit 3, so a background built from the low logical address bits would give different data, and the checkerboard checks would catch it. Two copies are built from the same stimulus: one with halting off and one with halting on. This lets the bench compare the first-fail capture after a full run with the early stop at the same faulty cell. A fault hook in the behavioural RAM forces a cell stuck at 0 or at 1, or inverts each read of a cell. The inverting fault produces several mismatches in one run, which exercises the first-fail capture.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

    localparam int ELEM_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_DRAIN,
        ST_DONE
    } state_e;

    // one memory operation: write flag plus data / expected bit
    typedef struct packed {
        logic wr;
        logic val;
    } op_t;

    // one march element: direction, op count (two = 1 means two ops), ops
    typedef struct packed {
        logic down;
        logic two;
        op_t  op0;
        op_t  op1;
    } elem_t;

    localparam op_t OP_W0 = '{wr: 1'b1, val: 1'b0};
    localparam op_t OP_W1 = '{wr: 1'b1, val: 1'b1};
    localparam op_t OP_R0 = '{wr: 1'b0, val: 1'b0};
    localparam op_t OP_R1 = '{wr: 1'b0, val: 1'b1};

    function automatic elem_t march_elem(input logic [1:0] mode, input logic [ELEM_W-1:0] idx);
        elem_t e;
        e = '{down: 1'b0, two: 1'b0, op0: OP_W0, op1: OP_W0};
        if (mode == 2'b00) begin
            case (idx)
                2'd1:    e = '{down: 1'b0, two: 1'b1, op0: OP_R0, op1: OP_W1};
                2'd2:    e = '{down: 1'b1, two: 1'b1, op0: OP_R1, op1: OP_W0};
                default: e = '{down: 1'b0, two: 1'b0, op0: OP_W0, op1: OP_W0};
            endcase
        end else begin
            case (idx)
                2'd1:    e.op0 = OP_R0;
                2'd2:    e.op0 = OP_W1;
                2'd3:    e.op0 = OP_R1;
                default: e.op0 = OP_W0;
            endcase
        end
        return e;
    endfunction

    function automatic logic elem_down(input logic [1:0] mode, input logic [ELEM_W-1:0] idx);
        return (mode == 2'b00) && (idx == 2'd2);
    endfunction

    function automatic logic [ELEM_W-1:0] final_elem(input logic [1:0] mode);
        return (mode == 2'b00) ? 2'd2 : 2'd3;
    endfunction

    function automatic logic uses_cb(input logic [1:0] mode);
        return mode[1];
    endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
    parameter int DEPTH  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_down,
    input  logic              step,
    input  logic              dir_down,
    output logic [ADDR_W-1:0] addr,
    output logic              at_end
);
    localparam logic [ADDR_W-1:0] TOP = ADDR_W'(DEPTH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= load_down ? TOP : '0;
        end else if (step) begin
            addr <= dir_down ? addr - 1'b1 : addr + 1'b1;
        end
    end

    assign at_end = dir_down ? (addr == '0) : (addr == TOP);

endmodule

// File: rtl/mbist_cb_map.sv
module mbist_cb_map #(
    parameter int COLS   = 8,
    parameter int ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              cb
);
    logic row_lsb;
    logic col_lsb;

    // physical position: row = addr / COLS, column = addr % COLS
    assign row_lsb = 1'(addr / ADDR_W'(COLS));
    assign col_lsb = 1'(addr % ADDR_W'(COLS));
    assign cb      = row_lsb ^ col_lsb;

endmodule

// File: rtl/mbist_resp_cap.sv
module mbist_resp_cap
    import mbist_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              active,
    input  logic              rd_issue,
    input  logic              rd_exp,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ELEM_W-1:0] rd_elem,
    input  logic              rdata,
    output logic              mismatch,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [ELEM_W-1:0] fail_elem,
    output logic              fail_exp
);
    logic              pend_v;
    logic              pend_exp;
    logic [ADDR_W-1:0] pend_addr;
    logic [ELEM_W-1:0] pend_elem;

    assign mismatch = pend_v && active && (rdata != pend_exp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_v    <= 1'b0;
            pend_exp  <= 1'b0;
            pend_addr <= '0;
            pend_elem <= '0;
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_elem <= '0;
            fail_exp  <= 1'b0;
        end else begin
            pend_v    <= rd_issue;
            pend_exp  <= rd_exp;
            pend_addr <= rd_addr;
            pend_elem <= rd_elem;
            if (clear) begin
                fail      <= 1'b0;
                fail_addr <= '0;
                fail_elem <= '0;
                fail_exp  <= 1'b0;
            end else if (mismatch && !fail) begin
                fail      <= 1'b1;
                fail_addr <= pend_addr;
                fail_elem <= pend_elem;
                fail_exp  <= pend_exp;
            end
        end
    end

endmodule

// File: rtl/mbist_march_ctrl.sv
module mbist_march_ctrl
    import mbist_pkg::*;
#(
    parameter int ROWS         = 4,
    parameter int COLS         = 8,
    parameter bit HALT_ON_FAIL = 1'b0,
    localparam int DEPTH       = ROWS * COLS,
    localparam int ADDR_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic              mem_wdata,
    input  logic              mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [ELEM_W-1:0] fail_elem,
    output logic              fail_exp
);
    state_e            state_q, state_d;
    logic [1:0]        mode_q;
    logic [ELEM_W-1:0] elem_q;
    logic              opi_q;

    elem_t             cur_e;
    op_t               cur_op;
    logic              issue, last_op, addr_end, elem_end, seq_end;
    logic              accept, halt, mismatch, cb_bit, data_bit;
    logic              ag_load, ag_load_down, ag_step;
    logic [ADDR_W-1:0] addr_q;

    // ---------------- sequencing decode ----------------
    always_comb begin
        cur_e        = march_elem(mode_q, elem_q);
        cur_op       = opi_q ? cur_e.op1 : cur_e.op0;
        last_op      = (opi_q == cur_e.two);
        issue        = (state_q == ST_RUN);
        elem_end     = issue && last_op && addr_end;
        seq_end      = elem_end && (elem_q == final_elem(mode_q));
        accept       = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
        halt         = HALT_ON_FAIL && mismatch;
        data_bit     = cur_op.val ^ (uses_cb(mode_q) & cb_bit);
        ag_load      = accept || (elem_end && !seq_end);
        ag_load_down = accept ? elem_down(mode, '0) : elem_down(mode_q, elem_q + 1'b1);
        ag_step      = issue && last_op && !addr_end;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_RUN;
            ST_RUN: begin
                if (halt)         state_d = ST_DONE;
                else if (seq_end) state_d = ST_DRAIN;
            end
            ST_DRAIN: state_d = ST_DONE;
            ST_DONE:  if (accept) state_d = ST_RUN;
            default:  state_d = ST_IDLE;
        endcase
    end

    // ---------------- element / operation pointers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 2'b00;
            elem_q <= '0;
            opi_q  <= 1'b0;
        end else if (accept) begin
            mode_q <= mode;
            elem_q <= '0;
            opi_q  <= 1'b0;
        end else if (issue) begin
            opi_q <= last_op ? 1'b0 : 1'b1;
            if (elem_end && !seq_end) begin
                elem_q <= elem_q + 1'b1;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        mem_addr  = addr_q;
        mem_we    = issue && cur_op.wr;
        mem_re    = issue && !cur_op.wr;
        mem_wdata = issue && cur_op.wr && data_bit;
        busy      = (state_q == ST_RUN) || (state_q == ST_DRAIN);
        done      = (state_q == ST_DONE);
    end

    // ---------------- sub-blocks ----------------
    mbist_addr_gen #(
        .DEPTH  (DEPTH),
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ag_load),
        .load_down (ag_load_down),
        .step      (ag_step),
        .dir_down  (cur_e.down),
        .addr      (addr_q),
        .at_end    (addr_end)
    );

    mbist_cb_map #(
        .COLS   (COLS),
        .ADDR_W (ADDR_W)
    ) u_cb (
        .addr (addr_q),
        .cb   (cb_bit)
    );

    mbist_resp_cap #(
        .ADDR_W (ADDR_W)
    ) u_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .active    (busy),
        .rd_issue  (issue && !cur_op.wr),
        .rd_exp    (data_bit),
        .rd_addr   (addr_q),
        .rd_elem   (elem_q),
        .rdata     (mem_rdata),
        .mismatch  (mismatch),
        .fail      (fail),
        .fail_addr (fail_addr),
        .fail_elem (fail_elem),
        .fail_exp  (fail_exp)
    );

endmodule

// File: rtl/mbist_march_chk.sv
module mbist_march_chk #(
    parameter int ADDR_W       = 5,
    parameter int DEPTH        = 32,
    parameter bit HALT_ON_FAIL = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [ADDR_W-1:0] fail_addr,
    input logic              mem_we,
    input logic              mem_re,
    input logic [ADDR_W-1:0] mem_addr
);
    assert_access_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_quiet_outside_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re));

    assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> (mem_addr <= ADDR_W'(DEPTH - 1)));

    assert_fail_capture_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> $stable(fail_addr));

    assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail);

    assert_start_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !fail && !done));

    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_done_busy_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    generate
        if (HALT_ON_FAIL) begin : g_halt
            assert_halt_on_fail_R10: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(fail) |-> done);
        end
    endgenerate

endmodule

bind mbist_march_ctrl mbist_march_chk #(
    .ADDR_W       (ADDR_W),
    .DEPTH        (DEPTH),
    .HALT_ON_FAIL (HALT_ON_FAIL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .fail_addr (fail_addr),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr)
);

// File: tb/mbist_march_ctrl_test.sv
`timescale 1ns/1ps

module mbist_tb_ram #(
    parameter int DEPTH = 32,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic          wdata,
    output logic          rdata,
    input  logic          f_en,
    input  logic [AW-1:0] f_addr,
    input  logic          f_kind,
    input  logic          f_val
);
    logic cells [DEPTH];
    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
        if (re) begin
            if (f_en && addr == f_addr) rdata <= f_kind ? ~cells[addr] : f_val;
            else                        rdata <= cells[addr];
        end
    end
endmodule

module mbist_march_ctrl_test;
    localparam int ROWS  = 4;
    localparam int COLS  = 8;
    localparam int DEPTH = ROWS * COLS;
    localparam int AW    = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] mode = 2'b00;
    logic f_en = 1'b0, f_kind = 1'b0, f_val = 1'b0;
    logic [AW-1:0] f_addr = '0;

    logic [AW-1:0] mem_addr, fail_addr, mem_addr_h, fail_addr_h;
    logic mem_we, mem_re, mem_wdata, mem_rdata, busy, done, fail, fail_exp;
    logic mem_we_h, mem_re_h, mem_wdata_h, mem_rdata_h, busy_h, done_h, fail_h, fail_exp_h;
    logic [1:0] fail_elem, fail_elem_h;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    mbist_march_ctrl #(.ROWS(ROWS), .COLS(COLS), .HALT_ON_FAIL(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail),
        .fail_addr(fail_addr), .fail_elem(fail_elem), .fail_exp(fail_exp));

    mbist_tb_ram #(.DEPTH(DEPTH), .AW(AW)) ram (
        .clk(clk), .we(mem_we), .re(mem_re), .addr(mem_addr), .wdata(mem_wdata),
        .rdata(mem_rdata), .f_en(f_en), .f_addr(f_addr), .f_kind(f_kind), .f_val(f_val));

    mbist_march_ctrl #(.ROWS(ROWS), .COLS(COLS), .HALT_ON_FAIL(1'b1)) uut_halt (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .mem_addr(mem_addr_h), .mem_we(mem_we_h), .mem_re(mem_re_h), .mem_wdata(mem_wdata_h),
        .mem_rdata(mem_rdata_h), .busy(busy_h), .done(done_h), .fail(fail_h),
        .fail_addr(fail_addr_h), .fail_elem(fail_elem_h), .fail_exp(fail_exp_h));

    mbist_tb_ram #(.DEPTH(DEPTH), .AW(AW)) ram_h (
        .clk(clk), .we(mem_we_h), .re(mem_re_h), .addr(mem_addr_h), .wdata(mem_wdata_h),
        .rdata(mem_rdata_h), .f_en(f_en), .f_addr(f_addr), .f_kind(f_kind), .f_val(f_val));

    // ---------------- reference model ----------------
    typedef struct {
        int addr;
        bit we;
        bit d;
        int elem;
    } op_s;

    op_s ops[$];
    bit  exp_fail;
    int  exp_idx, exp_addr, exp_elem;
    bit  exp_bit;

    function automatic bit cb_of(int a);
        return bit'(((a / COLS) % 2) ^ ((a % COLS) % 2));
    endfunction

    task automatic add_elem(int elem, bit down, int nops, bit w0, bit d0, bit w1, bit d1, bit cb);
        for (int k = 0; k < DEPTH; k++) begin
            int  a;
            op_s o;
            a = down ? DEPTH - 1 - k : k;
            o.addr = a; o.elem = elem;
            o.we = w0; o.d = d0 ^ (cb & cb_of(a));
            ops.push_back(o);
            if (nops == 2) begin
                o.we = w1; o.d = d1 ^ (cb & cb_of(a));
                ops.push_back(o);
            end
        end
    endtask

    task automatic build(logic [1:0] m);
        bit cb;
        ops.delete();
        cb = m[1];
        if (m == 2'b00) begin
            add_elem(0, 0, 1, 1, 0, 0, 0, 0);
            add_elem(1, 0, 2, 0, 0, 1, 1, 0);
            add_elem(2, 1, 2, 0, 1, 1, 0, 0);
        end else begin
            add_elem(0, 0, 1, 1, 0, 0, 0, cb);
            add_elem(1, 0, 1, 0, 0, 0, 0, cb);
            add_elem(2, 0, 1, 1, 1, 0, 0, cb);
            add_elem(3, 0, 1, 0, 1, 0, 0, cb);
        end
    endtask

    task automatic predict(bit fen, int fa, bit fkind, bit fv);
        bit model [DEPTH];
        bit v;
        exp_fail = 0; exp_idx = 0; exp_addr = 0; exp_elem = 0; exp_bit = 0;
        for (int i = 0; i < DEPTH; i++) model[i] = 0;
        for (int i = 0; i < ops.size(); i++) begin
            if (ops[i].we) begin
                model[ops[i].addr] = ops[i].d;
            end else begin
                v = model[ops[i].addr];
                if (fen && ops[i].addr == fa) v = fkind ? ~v : fv;
                if (v != ops[i].d && !exp_fail) begin
                    exp_fail = 1; exp_idx = i; exp_addr = ops[i].addr;
                    exp_elem = ops[i].elem; exp_bit = ops[i].d;
                end
            end
        end
    endtask

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // ---------------- one full test ----------------
    task automatic run_test(logic [1:0] m, bit fen, int fa, bit fkind, bit fv, bit poke, string tag);
        int T;
        int act, expv;
        build(m);
        predict(fen, fa, fkind, fv);
        T = ops.size();
        @(negedge clk);
        f_en = fen; f_addr = AW'(fa); f_kind = fkind; f_val = fv;
        mode = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c <= T + 1; c++) begin
            if (c > 0) @(negedge clk);
            start = (poke && c == T / 2) ? 1'b1 : 1'b0;
            if (c == 0)
                chk(busy && !fail && !done, "R7", "restart clears flags", {busy, fail, done}, 3'b100);
            if (c < T) begin
                act  = int'(mem_addr) + (int'(mem_we) << 8) + (int'(mem_re) << 9)
                     + (int'(mem_we & mem_wdata) << 10);
                expv = ops[c].addr + (int'(ops[c].we) << 8) + (int'(!ops[c].we) << 9)
                     + (int'(ops[c].we & ops[c].d) << 10);
                chk(act == expv, tag, $sformatf("R4 op %0d", c), act, expv);
            end
            if (poke && c == T / 2 + 2)
                chk(busy && !done, "R9", "start while busy ignored", {busy, done}, 2'b10);
            if (c == T)
                chk(busy && !done && !mem_we && !mem_re, "R8", "drain cycle",
                    {busy, done, mem_we, mem_re}, 4'b1000);
            if (c == T + 1) begin
                chk(done && !busy, "R8", "done after drain", {done, busy}, 2'b10);
                chk(fail == exp_fail, exp_fail ? "R12" : "R6", "fail flag", fail, exp_fail);
                if (exp_fail) begin
                    chk(int'(fail_addr) == exp_addr, "R6", "fail_addr", fail_addr, exp_addr);
                    chk(int'(fail_elem) == exp_elem, "R6", "fail_elem", fail_elem, exp_elem);
                    chk(fail_exp == exp_bit, "R6", "fail_exp", fail_exp, exp_bit);
                end else begin
                    chk(done_h && !fail_h, "R10", "halt copy completes clean", {done_h, fail_h}, 2'b10);
                end
            end
            if (exp_fail && c == exp_idx + 1) begin
                chk(!fail, "R5", "fail not yet visible", fail, 0);
                chk(!done_h, "R10", "halt copy not yet done", done_h, 0);
            end
            if (exp_fail && c == exp_idx + 2) begin
                chk(fail && int'(fail_addr) == exp_addr, "R5", "fail visible after compare",
                    int'(fail_addr), exp_addr);
                chk(done_h && fail_h && int'(fail_addr_h) == exp_addr && int'(fail_elem_h) == exp_elem,
                    "R10", "halt at first fail", {done_h, fail_h, fail_elem_h}, {2'b11, 2'(exp_elem)});
            end
            if (exp_fail && c == exp_idx + 3 && c <= T + 1)
                chk(!mem_we_h && !mem_re_h && !busy_h, "R10", "no access after halt",
                    {mem_we_h, mem_re_h, busy_h}, 0);
        end
        repeat (3) @(negedge clk);
        chk(done && fail == exp_fail && (!exp_fail || int'(fail_addr) == exp_addr), "R7",
            "flags held in DONE", {done, fail}, {1'b1, exp_fail});
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 50000, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !fail && !mem_we && !mem_re && fail_addr == '0, "R11",
            "reset state", {busy, done, fail, mem_we, mem_re}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_we && !mem_re, "R11", "idle after reset", {busy, done}, 0);

        run_test(2'b00, 0, 0, 0, 0, 1, "R1");   // clean, with start poke (R9)
        run_test(2'b01, 0, 0, 0, 0, 1, "R2");
        run_test(2'b10, 0, 0, 0, 0, 0, "R3");
        run_test(2'b11, 1, 9, 0, 0, 0, "R3");   // stuck-at-0, mode 3
        run_test(2'b00, 1, 0, 0, 1, 0, "R1");   // stuck-at-1 at lowest cell
        run_test(2'b00, 1, 31, 0, 0, 0, "R1");  // stuck-at-0, caught in descending element
        run_test(2'b01, 1, 31, 0, 0, 0, "R2");  // stuck-at-0 at top cell
        run_test(2'b10, 1, 10, 0, 0, 0, "R3");  // checkerboard, stuck-at-0
        run_test(2'b10, 1, 13, 0, 1, 0, "R3");  // checkerboard, stuck-at-1
        run_test(2'b01, 1, 3, 1, 0, 0, "R6");   // read-invert: two mismatches
        run_test(2'b00, 1, 20, 1, 0, 0, "R6");  // read-invert in three-element test

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule